// File: doc/BRIEF.md
# Pad Calibration Sequencer with Idle-Wait

This block sequences the calibration of a group of serial-link I/O pads. Software selects the pads to calibrate and pulses a start request. The block then drives a calibration code that counts up once per cycle for a fixed interval of at least 72 microseconds. For each selected pad it records the first code at which that pad's comparator reports a match. The comparators are outside the block; each one returns a single match bit.

After the sequencing interval the block holds the recorded codes. It applies them only once every lane shows the low-power idle condition, with both lines of each lane high. That condition passes through a two-flop synchroniser and must then hold for a programmable number of cycles.

Status is reported as one done bit per pad, an aggregate done flag and an active flag. The active flag is always the inverse of the aggregate. A restart is accepted while the block waits for idle. A restart is ignored while codes are being stepped or applied. A sticky timeout flag reports a wait for idle that has gone on too long. There is no data stream at the edge of this block: every pin is a plain control or status signal, so no valid/ready handshake applies.

Top module: `padcal_seq`

## Requirements
- R1: A start accepted with at least one pad enabled makes, from the next cycle, done_o all zero, active_o 1, and code_o 0 in the first sequencing cycle.
- R2: Sequencing lasts SEQ_CYC = ceil(SEQ_NS * CLK_KHZ / 1e6) cycles, with a minimum of 1. During sequencing code_o increases by one each cycle, modulo 2^CODE_W.
- R3: For each enabled pad, the code applied is the value of code_o in the first sequencing cycle in which that pad's code_match_i bit is high. A pad that never matches gets 0. Pad p's result is the field result_o[p*CODE_W +: CODE_W].
- R4: Lane idle means every lp_dp_i and lp_dn_i bit is high. Suppose the block is already waiting and idle is sampled at every edge from edge e onward. Then result_o changes at edge e+N+3 and the done bits are set at edge e+N+4, where N = stable_cycles_i and 0 counts as 1. Any non-idle sample restarts the count.
- R5: all_done_o is the AND of done_o over the pads enabled at the last accepted start, and active_o always equals its inverse. Pads not enabled in a run keep done_o at 0.
- R6: While waiting for idle, done_o stays all zero and active_o stays 1.
- R7: A start during the idle wait is accepted. It reloads the pad enables, discards the recorded codes, clears timeout_o and restarts sequencing from code 0.
- R8: A start during sequencing, or during the apply cycle or the done-setting cycle that follows it, has no effect: the code keeps counting and the run finishes as before.
- R9: Results are written one cycle before the done bits are set. Pads not enabled in the run keep their previous result.
- R10: A start with no pads enabled clears done_o, leaves all_done_o at 1 and active_o at 0, and starts no sequencing.
- R11: timeout_o rises at the TMO_CYC-th clock edge spent in the idle wait. It stays set until the next accepted start and does not change done_o or active_o.
- R12: After reset: done_o is 0, result_o is 0, timeout_o is 0, all_done_o is 1 and active_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| start_i | input | 1 | Start request, one-cycle pulse |
| pad_en_i | input | NPAD | Pads selected for the next run |
| code_match_i | input | NPAD | Comparator match, one bit per pad |
| lp_dp_i | input | NLANE | Lane positive line level (asynchronous) |
| lp_dn_i | input | NLANE | Lane negative line level (asynchronous) |
| stable_cycles_i | input | STAB_W | Number of idle cycles required before apply |
| code_o | output | CODE_W | Calibration code presented to the comparators |
| result_o | output | NPAD*CODE_W | Applied code per pad |
| done_o | output | NPAD | Per-pad done |
| all_done_o | output | 1 | All enabled pads done |
| active_o | output | 1 | Calibration in progress (inverse of all_done_o) |
| timeout_o | output | 1 | Idle wait exceeded TMO_CYC cycles |

## Verification
The bench builds the block with CLK_KHZ = 250, so the 72 us interval becomes an 18-cycle sequence. It uses CODE_W = 4, so the code wraps within that sequence and a second match at an early code must be ignored. TMO_CYC = 40 lets the timeout be reached within a few dozen cycles, and STAB_W = 3 lets the bench cover both a zero stability setting and a saturating stability counter. A behavioural reference model then follows every clock edge through directed restarts, ignored starts, runs with no pads and a long stretch of random start, enable and lane activity.

// File: rtl/padcal_pkg.sv
package padcal_pkg;

  typedef enum logic [2:0] {
    PC_IDLE  = 3'd0,
    PC_SEQ   = 3'd1,
    PC_WAIT  = 3'd2,
    PC_APPLY = 3'd3,
    PC_FIN   = 3'd4
  } pc_state_e;

  // Cycles needed to cover a span in nanoseconds at a clock in kHz, rounded up.
  function automatic int span_cycles(input longint ns, input longint khz);
    longint prod;
    longint cyc;
    prod = ns * khz;
    cyc  = (prod + 64'd999999) / 64'd1000000;
    if (cyc < 1) cyc = 1;
    return int'(cyc);
  endfunction

endpackage

// File: rtl/padcal_idle_sync.sv
module padcal_idle_sync #(
  parameter int NLANE  = 2,
  parameter int STAB_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLANE-1:0]  lp_dp_i,
  input  logic [NLANE-1:0]  lp_dn_i,
  input  logic [STAB_W-1:0] stable_cycles_i,
  output logic              idle_ok_o
);
  localparam int RAW_W = 2 * NLANE;
  localparam logic [STAB_W-1:0] CNT_MAX = '1;

  logic [RAW_W-1:0]  raw;
  logic [RAW_W-1:0]  meta_q;
  logic [RAW_W-1:0]  sync_q;
  logic [STAB_W-1:0] run_q;
  logic [STAB_W-1:0] need;
  logic              sync_idle;
  logic              raw_idle;

  assign raw       = {lp_dp_i, lp_dn_i};
  assign raw_idle  = &raw;
  assign sync_idle = &sync_q;
  assign need      = (stable_cycles_i == '0) ? STAB_W'(1) : stable_cycles_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      run_q  <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      if (!sync_idle)            run_q <= '0;
      else if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
    end
  end

  assign idle_ok_o = sync_idle && (run_q >= need);

  // Idle can only be reported once a sampled idle has crossed both flops.
  AST_IDLE_SYNCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_ok_o |-> $past(raw_idle, 2)); // R4

endmodule

// File: rtl/padcal_ctrl.sv
module padcal_ctrl
  import padcal_pkg::*;
#(
  parameter int SEQ_CYC = 18,
  parameter int TMO_CYC = 40,
  parameter int CODE_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              en_any_i,
  input  logic              idle_ok_i,
  output pc_state_e         state_o,
  output logic [CODE_W-1:0] code_o,
  output logic              restart_o,
  output logic              timeout_o
);
  localparam int SEQ_W = $clog2(SEQ_CYC + 1);
  localparam int TMO_W = $clog2(TMO_CYC + 1);
  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(SEQ_CYC - 1);
  localparam logic [TMO_W-1:0] TMO_LIM  = TMO_W'(TMO_CYC);
  localparam logic [TMO_W-1:0] TMO_PRE  = TMO_W'(TMO_CYC - 1);

  pc_state_e         state_q, state_d;
  logic [SEQ_W-1:0]  seq_q;
  logic [TMO_W-1:0]  wait_q;
  logic [CODE_W-1:0] code_q;
  logic              tmo_q;
  logic              accept;

  // Starts are taken only when idle or while waiting for lane idle.
  assign accept = start_i && ((state_q == PC_IDLE) || (state_q == PC_WAIT));

  always_comb begin
    state_d = state_q;
    case (state_q)
      PC_IDLE:  if (accept) state_d = en_any_i ? PC_SEQ : PC_IDLE;
      PC_SEQ:   if (seq_q == SEQ_LAST) state_d = PC_WAIT;
      PC_WAIT: begin
        if (accept)         state_d = en_any_i ? PC_SEQ : PC_IDLE;
        else if (idle_ok_i) state_d = PC_APPLY;
      end
      PC_APPLY: state_d = PC_FIN;
      PC_FIN:   state_d = PC_IDLE;
      default:  state_d = PC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PC_IDLE;
      seq_q   <= '0;
      wait_q  <= '0;
      code_q  <= '0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        seq_q  <= '0;
        wait_q <= '0;
        code_q <= '0;
        tmo_q  <= 1'b0;
      end else if (state_q == PC_SEQ) begin
        if (seq_q != SEQ_LAST) seq_q <= seq_q + 1'b1;
        code_q <= code_q + 1'b1;
      end else if (state_q == PC_WAIT) begin
        if (wait_q == TMO_PRE) tmo_q <= 1'b1;
        if (wait_q != TMO_LIM) wait_q <= wait_q + 1'b1;
      end
    end
  end

  assign state_o   = state_q;
  assign code_o    = code_q;
  assign restart_o = accept;
  assign timeout_o = tmo_q;

  AST_CODE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PC_SEQ && seq_q != SEQ_LAST) |=> (code_q == ($past(code_q) + 1'b1))); // R2

  AST_SEQ_IGNORES_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PC_SEQ && start_i && seq_q != SEQ_LAST) |=> (state_q == PC_SEQ)); // R8

  AST_WAIT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PC_WAIT && start_i && en_any_i) |=> (state_q == PC_SEQ && code_q == '0 && !tmo_q)); // R7

  AST_TMO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_q && !accept) |=> tmo_q); // R11

endmodule

// File: rtl/padcal_pad_slice.sv
module padcal_pad_slice #(
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              en_i,
  input  logic              seq_i,
  input  logic              apply_i,
  input  logic              finish_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              match_i,
  output logic [CODE_W-1:0] result_o,
  output logic              done_o,
  output logic              en_q_o
);
  logic              en_q;
  logic              caught_q;
  logic [CODE_W-1:0] cap_q;
  logic [CODE_W-1:0] res_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      caught_q <= 1'b0;
      cap_q    <= '0;
      res_q    <= '0;
      done_q   <= 1'b0;
    end else if (restart_i) begin
      en_q     <= en_i;
      caught_q <= 1'b0;
      cap_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      if (seq_i && en_q && match_i && !caught_q) begin
        cap_q    <= code_i;
        caught_q <= 1'b1;
      end
      if (apply_i && en_q) res_q  <= cap_q;
      if (finish_i)        done_q <= en_q;
    end
  end

  assign result_o = res_q;
  assign done_o   = done_q;
  assign en_q_o   = en_q;

  // A recorded code never changes later in the same run.
  AST_CAPTURE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (caught_q && !restart_i) |=> $stable(cap_q)); // R3

endmodule

// File: rtl/padcal_seq.sv
module padcal_seq
  import padcal_pkg::*;
#(
  parameter int NPAD    = 4,
  parameter int NLANE   = 2,
  parameter int CODE_W  = 6,
  parameter int STAB_W  = 4,
  parameter int SEQ_NS  = 72000,
  parameter int CLK_KHZ = 125000,
  parameter int TMO_CYC = 4096
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [NPAD-1:0]        pad_en_i,
  input  logic [NPAD-1:0]        code_match_i,
  input  logic [NLANE-1:0]       lp_dp_i,
  input  logic [NLANE-1:0]       lp_dn_i,
  input  logic [STAB_W-1:0]      stable_cycles_i,
  output logic [CODE_W-1:0]      code_o,
  output logic [NPAD*CODE_W-1:0] result_o,
  output logic [NPAD-1:0]        done_o,
  output logic                   all_done_o,
  output logic                   active_o,
  output logic                   timeout_o
);
  localparam int SEQ_CYC = span_cycles(longint'(SEQ_NS), longint'(CLK_KHZ));

  pc_state_e         state;
  logic              restart;
  logic              idle_ok;
  logic [NPAD-1:0]   en_mask;
  logic [CODE_W-1:0] code;

  padcal_idle_sync #(
    .NLANE  (NLANE),
    .STAB_W (STAB_W)
  ) u_idle (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .lp_dp_i         (lp_dp_i),
    .lp_dn_i         (lp_dn_i),
    .stable_cycles_i (stable_cycles_i),
    .idle_ok_o       (idle_ok)
  );

  padcal_ctrl #(
    .SEQ_CYC (SEQ_CYC),
    .TMO_CYC (TMO_CYC),
    .CODE_W  (CODE_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .en_any_i  (|pad_en_i),
    .idle_ok_i (idle_ok),
    .state_o   (state),
    .code_o    (code),
    .restart_o (restart),
    .timeout_o (timeout_o)
  );

  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    padcal_pad_slice #(
      .CODE_W (CODE_W)
    ) u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart),
      .en_i      (pad_en_i[p]),
      .seq_i     (state == PC_SEQ),
      .apply_i   (state == PC_APPLY),
      .finish_i  (state == PC_FIN),
      .code_i    (code),
      .match_i   (code_match_i[p]),
      .result_o  (result_o[p*CODE_W +: CODE_W]),
      .done_o    (done_o[p]),
      .en_q_o    (en_mask[p])
    );
  end

  assign code_o     = code;
  assign all_done_o = &(done_o | ~en_mask);
  assign active_o   = ~all_done_o;

  AST_WAIT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == PC_WAIT) |-> (active_o && done_o == '0)); // R6

  AST_RESULT_BEFORE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == PC_FIN) |-> (done_o == '0)); // R9

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && pad_en_i != '0) |=> (active_o && done_o == '0)); // R1

  AST_NO_PADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && pad_en_i == '0) |=> (all_done_o && !active_o && done_o == '0)); // R10

endmodule

// File: tb/padcal_seq_bench.sv
module padcal_seq_bench;
  localparam int NPAD = 4;
  localparam int NLANE = 2;
  localparam int CW = 4;
  localparam int SW = 3;
  localparam int TMO = 40;
  localparam int SEQ_EXP = 18;  // ceil(72000 ns * 250 kHz / 1e6)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NPAD-1:0] pad_en = '0;
  logic [NPAD-1:0] match;
  logic [NLANE-1:0] dp = '0, dn = '0;
  logic [SW-1:0] stab = 3'd3;
  logic [CW-1:0] code;
  logic [NPAD*CW-1:0] res;
  logic [NPAD-1:0] done;
  logic all_done, active, tmo;

  logic [NPAD-1:0] match_on = 4'b0111;
  logic [CW-1:0] tgt [NPAD];

  int checks = 0;
  int errors = 0;
  bit fin = 1'b0;

  always #4 clk = ~clk;

  always_comb
    for (int p = 0; p < NPAD; p++) match[p] = match_on[p] && (code == tgt[p]);

  padcal_seq #(
    .NPAD(NPAD), .NLANE(NLANE), .CODE_W(CW), .STAB_W(SW),
    .SEQ_NS(72000), .CLK_KHZ(250), .TMO_CYC(TMO)
  ) u_padcal_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pad_en_i(pad_en),
    .code_match_i(match), .lp_dp_i(dp), .lp_dn_i(dn), .stable_cycles_i(stab),
    .code_o(code), .result_o(res), .done_o(done), .all_done_o(all_done),
    .active_o(active), .timeout_o(tmo)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 stepping, 2 waiting, 3 apply, 4 finish
  int m_phase, m_seq, m_code, m_wcnt, m_run;
  int m_cap [NPAD];
  int m_res [NPAD];
  bit m_caught [NPAD];
  logic [NPAD-1:0] m_en, m_done;
  logic [3:0] m_s1, m_s2;
  bit m_tmo;

  always @(posedge clk) begin
    int ph, need;
    bit ok, acc;
    if (!rst_n) begin
      m_phase = 0; m_seq = 0; m_code = 0; m_wcnt = 0; m_run = 0;
      m_en = '0; m_done = '0; m_s1 = '0; m_s2 = '0; m_tmo = 0;
      for (int p = 0; p < NPAD; p++) begin m_cap[p] = 0; m_res[p] = 0; m_caught[p] = 0; end
    end else begin
      ph = m_phase;
      need = (stab == 0) ? 1 : int'(stab);
      ok = (m_s2 == 4'hF) && (m_run >= need);
      if (m_s2 == 4'hF) begin if (m_run < 7) m_run++; end else m_run = 0;
      m_s2 = m_s1;
      m_s1 = {dp, dn};
      acc = start && (ph == 0 || ph == 2);
      if (acc) begin
        m_done = '0; m_en = pad_en; m_tmo = 0; m_wcnt = 0; m_seq = 0; m_code = 0;
        for (int p = 0; p < NPAD; p++) begin m_cap[p] = 0; m_caught[p] = 0; end
        m_phase = (pad_en != 0) ? 1 : 0;
      end else if (ph == 1) begin
        for (int p = 0; p < NPAD; p++)
          if (m_en[p] && match_on[p] && m_code == int'(tgt[p]) && !m_caught[p]) begin
            m_cap[p] = m_code; m_caught[p] = 1;
          end
        if (m_seq == SEQ_EXP - 1) m_phase = 2; else m_seq++;
        m_code = (m_code + 1) % (1 << CW);
      end else if (ph == 2) begin
        if (ok) m_phase = 3;
        if (m_wcnt == TMO - 1) m_tmo = 1;
        if (m_wcnt != TMO) m_wcnt++;
      end else if (ph == 3) begin
        for (int p = 0; p < NPAD; p++) if (m_en[p]) m_res[p] = m_cap[p];
        m_phase = 4;
      end else if (ph == 4) begin
        m_done = m_en;
        m_phase = 0;
      end
    end
  end

  always @(negedge clk) begin
    logic [NPAD*CW-1:0] er;
    logic ead;
    if (rst_n && !fin) begin
      for (int p = 0; p < NPAD; p++) er[p*CW +: CW] = CW'(m_res[p]);
      ead = &(m_done | ~m_en);
      chk("R5 done_o", 64'(done), 64'(m_done));
      chk("R5 all_done_o", 64'(all_done), 64'(ead));
      chk("R5 active_o", 64'(active), 64'(!ead));
      chk("R11 timeout_o", 64'(tmo), 64'(m_tmo));
      chk("R9 result_o", 64'(res), 64'(er));
      if (m_phase == 1) chk("R2 code_o", 64'(code), 64'(m_code));
    end
  end

  task automatic pulse();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] c0;
    int n;
    tgt[0] = 4'd5; tgt[1] = 4'd1; tgt[2] = 4'd9; tgt[3] = 4'd14;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    chk("R12 done", 64'(done), 64'h0);
    chk("R12 all_done", 64'(all_done), 64'h1);
    chk("R12 active", 64'(active), 64'h0);
    chk("R12 timeout", 64'(tmo), 64'h0);
    chk("R12 result", 64'(res), 64'h0);

    // Run 1, abandoned in the wait by a restart
    pad_en = 4'b1011;
    @(negedge clk);
    pulse();
    chk("R1 active", 64'(active), 64'h1);
    chk("R1 done", 64'(done), 64'h0);
    chk("R1 code", 64'(code), 64'h0);
    repeat (4) @(negedge clk);
    c0 = code;
    pulse();
    chk("R8 code keeps stepping", 64'(code), 64'(CW'(c0 + 1'b1)));
    repeat (60) @(negedge clk);
    chk("R11 timeout set", 64'(tmo), 64'h1);
    chk("R6 active while waiting", 64'(active), 64'h1);
    chk("R6 done while waiting", 64'(done), 64'h0);

    // Run 2, restarted from the wait, then idle arrives
    pad_en = 4'b0110;
    pulse();
    chk("R7 code restarts", 64'(code), 64'h0);
    chk("R7 timeout cleared", 64'(tmo), 64'h0);
    chk("R7 active", 64'(active), 64'h1);
    repeat (25) @(negedge clk);
    dp = '1; dn = '1;
    n = 0;
    while (!all_done && n < 50) begin @(negedge clk); n++; end
    chk("R4 idle to done latency", 64'(n), 64'd8);
    chk("R3 pad1 first match after wrap", 64'(res[1*CW +: CW]), 64'd1);
    chk("R3 pad2 code", 64'(res[2*CW +: CW]), 64'd9);
    chk("R9 pad0 not enabled keeps result", 64'(res[0 +: CW]), 64'd0);
    chk("R5 done only enabled pads", 64'(done), 64'b0110);

    // Run 3, lanes already idle, one pad never matches
    pad_en = 4'b1111;
    pulse();
    n = 0;
    while (!all_done && n < 100) begin @(negedge clk); n++; end
    chk("R3 all pads applied", 64'(res), 64'h0915);
    chk("R5 all done", 64'(done), 64'hF);

    // No pads enabled
    pad_en = 4'b0000;
    pulse();
    chk("R10 all_done", 64'(all_done), 64'h1);
    chk("R10 active", 64'(active), 64'h0);
    chk("R10 done cleared", 64'(done), 64'h0);
    chk("R10 no sequencing", 64'(code), 64'h0);

    // Random activity, checked by the reference model each cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      start = ($urandom % 29) == 0;
      if (($urandom % 7) == 0) pad_en = NPAD'($urandom);
      if (($urandom % 11) == 0) begin dp = NLANE'($urandom | 1); dn = NLANE'($urandom | 2); end
      if (($urandom % 13) == 0) begin dp = '1; dn = '1; end
      if (($urandom % 37) == 0) stab = SW'($urandom);
      if (($urandom % 53) == 0) match_on = NPAD'($urandom);
    end
    start = 1'b0;
    repeat (10) @(negedge clk);
    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule